// File: doc/BRIEF.md
# Condition Flag Generator and Processor Status Register

This unit sits after the adder and the barrel shifter of a 32-bit datapath. For each operation it is told whether the operation was arithmetic or logical. It takes the 32-bit result, the adder carry-out, the sign bits of both adder operands and the last bit the shifter pushed out. From these it forms the negative, zero, carry and overflow condition flags.

The flags live in the top nibble of a 32-bit processor status word. The low byte of that word holds a 5-bit mode code, an instruction-set state bit for the compact 16-bit encoding, and two interrupt-mask bits. The datapath raises `flag_upd` when an operation should set flags. Privileged software can replace the entire word with `sw_wr`. The current word can always be read on `psr_q`.

The carry source follows the operation class. Arithmetic operations take the adder carry-out, and logical operations take the shifter's last shifted-out bit. Logical operations keep the overflow flag as it was.

Top module: `psr_flag_unit`

## Requirements
- R1: After reset `psr_q` reads 32'h0000_00D3. That is mode code 5'b10011 in bits 4:0, bit 5 (16-bit instruction state) clear, both mask bits 7 and 6 set, and flag bits 31:28 clear.
- R2: On a flag update, bit 31 (N) takes bit 31 of `res`, for both operation classes.
- R3: On a flag update, bit 30 (Z) is 1 exactly when all 32 bits of `res` are zero, for both operation classes.
- R4: On an arithmetic flag update (`op_logic`=0), bit 29 (C) takes `add_cout`.
- R5: On a logical flag update (`op_logic`=1), bit 29 (C) takes `shift_out`.
- R6: On an arithmetic flag update, bit 28 (V) is 1 exactly when `add_a_msb` equals `add_b_msb` and `res[31]` differs from them.
- R7: On a logical flag update, bit 28 (V) keeps its previous value.
- R8: With `flag_upd` and `sw_wr` both low, `psr_q` does not change, whatever the datapath inputs do.
- R9: A flag update without `sw_wr` leaves bits 27:0 unchanged.
- R10: When `sw_wr` is high, `psr_q` equals `sw_data` after the next clock edge, even if `flag_upd` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_logic | input | 1 | 1 = logical operation, 0 = arithmetic |
| flag_upd | input | 1 | Load condition flags this cycle |
| res | input | 32 | Operation result |
| add_cout | input | 1 | Adder carry out of bit 31 |
| add_a_msb | input | 1 | Sign bit of adder operand A |
| add_b_msb | input | 1 | Sign bit of adder operand B as applied |
| shift_out | input | 1 | Last bit shifted out by the barrel shifter |
| sw_wr | input | 1 | Whole-word write strobe from privileged software |
| sw_data | input | 32 | Whole-word write value |
| psr_q | output | 32 | Current status word |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, a 5-bit mode field and the supervisor reset mode code. These defaults place the flags at bits 31:28 and give the 0xD3 reset word, so both can be checked directly. With a 32-bit result, the signed boundary cases are reachable: 0x7FFFFFFF plus one, wrap to zero with a carry, and the sign flip from subtracting a negative number. Logical updates are then placed after overflow was set and after it was cleared, which shows that V is held in both states.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic logic sign_flip(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  function automatic logic all_zero32(input logic [31:0] r);
    return r == 32'd0;
  endfunction
endpackage

// File: rtl/psr_flag_calc.sv
module psr_flag_calc
  import psr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          op_logic,
  input  logic [DW-1:0] res,
  input  logic          add_cout,
  input  logic          add_a_msb,
  input  logic          add_b_msb,
  input  logic          shift_out,
  input  logic          v_prev,
  output flags_t        flags_nxt
);
  always_comb begin
    flags_nxt.n = res[DW-1];
    flags_nxt.z = (res == '0);
    if (op_logic) begin
      flags_nxt.c = shift_out;
      flags_nxt.v = v_prev;
    end else begin
      flags_nxt.c = add_cout;
      flags_nxt.v = sign_flip(add_a_msb, add_b_msb, res[DW-1]);
    end
  end
endmodule

// File: rtl/psr_store.sv
module psr_store
  import psr_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          MODE_W     = 5,
  parameter logic [4:0]  RESET_MODE = 5'b10011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_flags,
  input  logic          load_word,
  input  flags_t        flags_in,
  input  logic [DW-1:0] word_in,
  output logic [DW-1:0] q
);
  localparam int FLAG_LO = DW - 4;
  localparam logic [DW-1:0] RST_WORD =
    (DW'(RESET_MODE) & DW'((1 << MODE_W) - 1)) | DW'(8'hC0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_WORD;
    end else if (load_word) begin
      q <= word_in;
    end else if (load_flags) begin
      q[DW-1:FLAG_LO] <= flags_in;
    end
  end
endmodule

// File: rtl/psr_flag_unit.sv
module psr_flag_unit
  import psr_pkg::*;
#(
  parameter int         DW         = 32,
  parameter int         MODE_W     = 5,
  parameter logic [4:0] RESET_MODE = 5'b10011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_logic,
  input  logic          flag_upd,
  input  logic [DW-1:0] res,
  input  logic          add_cout,
  input  logic          add_a_msb,
  input  logic          add_b_msb,
  input  logic          shift_out,
  input  logic          sw_wr,
  input  logic [DW-1:0] sw_data,
  output logic [DW-1:0] psr_q
);
  localparam int V_POS = DW - 4;

  flags_t flags_nxt;
  logic   flag_load_evt;
  logic   v_prev;

  assign v_prev        = psr_q[V_POS];
  assign flag_load_evt = flag_upd & ~sw_wr;

  psr_flag_calc #(.DW(DW)) calc_i (
    .op_logic  (op_logic),
    .res       (res),
    .add_cout  (add_cout),
    .add_a_msb (add_a_msb),
    .add_b_msb (add_b_msb),
    .shift_out (shift_out),
    .v_prev    (v_prev),
    .flags_nxt (flags_nxt)
  );

  psr_store #(.DW(DW), .MODE_W(MODE_W), .RESET_MODE(RESET_MODE)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_flags (flag_load_evt),
    .load_word  (sw_wr),
    .flags_in   (flags_nxt),
    .word_in    (sw_data),
    .q          (psr_q)
  );
endmodule

// File: rtl/psr_flag_chk.sv
module psr_flag_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_logic,
  input logic          flag_upd,
  input logic [DW-1:0] res,
  input logic          add_cout,
  input logic          shift_out,
  input logic          sw_wr,
  input logic [DW-1:0] sw_data,
  input logic [DW-1:0] psr_q,
  input logic          flag_load_evt
);
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_upd && !sw_wr) |=> $stable(psr_q)); // R8
  AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    flag_load_evt |=> psr_q[DW-5:0] == $past(psr_q[DW-5:0])); // R9
  AST_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> psr_q == $past(sw_data)); // R10
  AST_V_HELD_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_load_evt && op_logic) |=> psr_q[DW-4] == $past(psr_q[DW-4])); // R7
  AST_C_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_load_evt && !op_logic) |=> psr_q[DW-3] == $past(add_cout)); // R4
  AST_C_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_load_evt && op_logic) |=> psr_q[DW-3] == $past(shift_out)); // R5
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_load_evt |=> psr_q[DW-2] == ($past(res) == '0)); // R3
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_load_evt |=> psr_q[DW-1] == $past(res[DW-1])); // R2
endmodule

bind psr_flag_unit psr_flag_chk #(.DW(DW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_logic      (op_logic),
  .flag_upd      (flag_upd),
  .res           (res),
  .add_cout      (add_cout),
  .shift_out     (shift_out),
  .sw_wr         (sw_wr),
  .sw_data       (sw_data),
  .psr_q         (psr_q),
  .flag_load_evt (flag_load_evt)
);

// File: tb/psr_flag_unit_tb_top.sv
module psr_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_logic = 1'b0, flag_upd = 1'b0, add_cout = 1'b0;
  logic        add_a_msb = 1'b0, add_b_msb = 1'b0, shift_out = 1'b0, sw_wr = 1'b0;
  logic [31:0] res = '0, sw_data = '0;
  logic [31:0] psr_q;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t        sb_q[$];
  logic [31:0] model;

  always #10 clk = ~clk;

  psr_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_logic(op_logic), .flag_upd(flag_upd),
    .res(res), .add_cout(add_cout), .add_a_msb(add_a_msb), .add_b_msb(add_b_msb),
    .shift_out(shift_out), .sw_wr(sw_wr), .sw_data(sw_data), .psr_q(psr_q)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected word
  task automatic step(input logic lg, input logic fu, input logic [31:0] r,
                      input logic co, input logic sa, input logic sbit,
                      input logic so, input logic wr, input logic [31:0] wd,
                      input string tag);
    exp_t e;
    @(negedge clk);
    op_logic = lg; flag_upd = fu; res = r; add_cout = co;
    add_a_msb = sa; add_b_msb = sbit; shift_out = so; sw_wr = wr; sw_data = wd;
    if (wr) model = wd;
    else if (fu) begin
      model[31] = r[31];
      model[30] = (r == 32'd0);
      model[29] = lg ? so : co;
      if (!lg) model[28] = (sa == sbit) && (r[31] != sa);
    end
    e.val = model;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: a quarter period after each edge
  always @(posedge clk) begin
    #5;
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(psr_q, e.val, e.tag);
    end
  end

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model = 32'h0000_00D3;
    #35;
    check(psr_q, 32'h0000_00D3, "R1 reset word");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(psr_q, 32'h0000_00D3, "R1 reset word held");
    // arithmetic: 7FFFFFFF + 1 -> N and V set
    step(0, 1, 32'h8000_0000, 0, 0, 0, 1, 0, '0, "R2 R6 signed overflow");
    // logical after V set: V held, C from shifter
    step(1, 1, 32'h0000_0010, 1, 1, 0, 1, 0, '0, "R5 R7 V held set");
    // arithmetic wrap FFFFFFFF + 1 -> Z C, V clear
    step(0, 1, 32'h0000_0000, 1, 1, 0, 0, 0, '0, "R3 R4 wrap to zero");
    // logical zero result, negative flag clear, V held clear
    step(1, 1, 32'h0000_0000, 1, 0, 0, 0, 0, '0, "R3 R5 R7 logic zero");
    // logical negative result
    step(1, 1, 32'hF000_0001, 0, 0, 0, 1, 0, '0, "R2 R5 logic negative");
    // negative operands giving positive result: V set
    step(0, 1, 32'h7FFF_FFFE, 1, 1, 1, 0, 0, '0, "R6 R4 negative overflow");
    // mixed signs never overflow
    step(0, 1, 32'h8000_0000, 0, 1, 0, 1, 0, '0, "R6 mixed signs");
    // idle cycles with busy inputs
    step(0, 0, 32'h0000_0000, 1, 0, 0, 1, 0, '0, "R8 idle arith");
    step(1, 0, 32'hFFFF_FFFF, 0, 1, 1, 0, 0, 32'hDEAD_BEEF, "R8 idle logic");
    // software write with flag_upd also high
    step(0, 1, 32'h0000_0000, 1, 0, 0, 1, 1, 32'h1234_5678, "R10 write wins");
    step(1, 1, 32'hFFFF_FFFF, 0, 0, 0, 1, 0, '0, "R9 R5 low bits kept");
    step(0, 1, 32'h0000_0001, 0, 0, 0, 0, 0, '0, "R9 R6 low bits kept arith");
    step(0, 0, 32'h0, 0, 0, 0, 0, 1, 32'hF000_001F, "R10 full write");
    step(1, 1, 32'h0000_0002, 0, 0, 0, 0, 0, '0, "R7 R9 V held after write");
    step(0, 0, 32'h0, 0, 0, 0, 0, 0, '0, "R8 quiet");
    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule